// File: doc/BRIEF.md
# Multiplexed Bus Machine-Cycle Sequencer

This block produces the T-state timing of an 8-bit processor's external memory bus. The low address byte and the data byte share one bus; a latch-enable strobe tells external logic when that bus holds address. The block runs three kinds of machine cycle: opcode fetch, memory read and memory write. It also chains a fetch and an operand read into one two-byte load-immediate sequence. Each T-state lasts two periods of the input clock, because the T-state rate is the input clock divided by two.

A requester presents a cycle kind, an address and write data while the block is idle. Fetches take their address from an internal program counter that starts at `RESET_PC`; plain reads and writes take `req_addr`. The shared bus is modelled as an output byte with an output-enable flag plus a separate input byte for read data. A fetched byte lands in `opcode` and any other read byte lands in `rdata`. A `done` pulse lasting one T-state marks the end of every machine cycle.

The controller has the states IDLE, T1, T2, T3 and T4. Its transitions are:
- IDLE→T1 on an accepted request.
- T1→T2 and T2→T3 at the end of each T-state.
- T3→T4 for a fetch, and T3→IDLE for a read or write.
- T4→T1 when an operand read is chained, and T4→IDLE otherwise.

Top module: `bus_cycle_seq`

## Requirements
- R1: During reset and whenever the block is idle: `busy`=0, `ale`=0, `ad_oe`=0, `rd_n`=1, `wr_n`=1, `addr_hi`=0. In addition, `done`=0 out of reset.
- R2: Every T-state spans exactly two `clk` periods. A request seen with `req_valid`=1 at a clock edge in IDLE starts T1 at that edge.
- R3: Throughout T1, `ale`=1, `ad_oe`=1 and `ad_out` is the low address byte. Throughout the whole machine cycle, `addr_hi` is the high address byte (for example 8'hFF for address 16'hFFFF).
- R4: In T2 and T3 of a fetch or read, `rd_n`=0, `ad_oe`=0 and `wr_n`=1. `rd_n` and `wr_n` are never low together.
- R5: In T2 and T3 of a write, `wr_n`=0, `ad_oe`=1, `ad_out` is the write data and `rd_n`=1. The written byte is visible to a later read of the same address.
- R6: A fetch lasts four T-states and a read or write lasts three. In T4 every strobe is inactive and the bus is released.
- R7: `req_kind` 2'd0 requests a fetch at the program counter. The byte on `ad_in` at the end of T3 is stored in `opcode`, and the program counter then advances by one.
- R8: `req_kind` 2'd1 requests a read of `req_addr`, and `req_kind` 2'd2 a write of `req_wdata` to `req_addr`. A read stores the byte on `ad_in` at the end of T3 in `rdata`. Neither kind changes the program counter.
- R9: `req_kind` 2'd3 runs a fetch at the program counter followed, with no idle gap, by an operand read at the program counter plus one. This is seven T-states in total, and the program counter ends two higher.
- R10: After every machine cycle, `done` is high for exactly two `clk` periods, starting at the edge that ends the cycle. The captured byte is valid while `done` is high.
- R11: A request presented while `busy`=1 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock at twice the T-state rate |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken only in IDLE |
| req_kind | input | 2 | 0 fetch, 1 read, 2 write, 3 load-immediate |
| req_addr | input | AW | Address for read and write |
| req_wdata | input | DW | Data for write |
| ad_in | input | DW | Byte the memory places on the shared bus |
| busy | output | 1 | A machine cycle is in progress |
| addr_hi | output | AW-DW | High address byte |
| ad_out | output | DW | Value driven onto the shared bus |
| ad_oe | output | 1 | Shared bus driven by the block |
| ale | output | 1 | Address latch enable, high in T1 |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| opcode | output | DW | Last fetched byte |
| rdata | output | DW | Last read or operand byte |
| done | output | 1 | One-T-state end-of-cycle pulse |

## Verification
The bench builds the block with its defaults: a 16-bit address, an 8-bit bus and a program counter starting at zero. With these values a small program at the bottom of memory drives two load-immediate sequences and the plain fetches around them. A read at 16'hFFFF drives `addr_hi` to all ones. A write followed by reads exercises the shared bus in both directions, and a request raised mid-cycle exercises the rule that requests are ignored while busy.

// File: rtl/bus_seq_pkg.sv
package bus_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_T1,
        ST_T2,
        ST_T3,
        ST_T4
    } tstate_e;

    typedef enum logic [1:0] {
        RQ_FETCH = 2'd0,
        RQ_READ  = 2'd1,
        RQ_WRITE = 2'd2,
        RQ_LDI   = 2'd3
    } req_e;

    typedef enum logic [1:0] {
        MC_FETCH = 2'd0,
        MC_READ  = 2'd1,
        MC_WRITE = 2'd2
    } mc_e;

endpackage

// File: rtl/bus_cycle_fsm.sv
module bus_cycle_fsm
    import bus_seq_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8,
    parameter logic [AW-1:0] RESET_PC = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [1:0]    req_kind,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output tstate_e       tstate,
    output mc_e           mc,
    output logic [AW-1:0] cur_addr,
    output logic [DW-1:0] cur_wdata,
    output logic          cap_en,
    output logic          cycle_end
);

    tstate_e       state_q, state_d;
    logic          ph_q;
    mc_e           mc_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] wdata_q;
    logic          chain_q;
    logic          oper_q;
    logic [AW-1:0] pc_q;
    logic          t_end;
    logic          last_t;

    assign t_end     = (state_q != ST_IDLE) && ph_q;
    assign last_t    = (state_q == ST_T4) || ((state_q == ST_T3) && (mc_q != MC_FETCH));
    assign cycle_end = t_end && last_t;
    assign cap_en    = t_end && (state_q == ST_T3) && (mc_q != MC_WRITE);

    assign tstate    = state_q;
    assign mc        = mc_q;
    assign cur_addr  = addr_q;
    assign cur_wdata = wdata_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_valid) state_d = ST_T1;
            ST_T1:   if (ph_q) state_d = ST_T2;
            ST_T2:   if (ph_q) state_d = ST_T3;
            ST_T3:   if (ph_q) state_d = (mc_q == MC_FETCH) ? ST_T4 : ST_IDLE;
            ST_T4:   if (ph_q) state_d = chain_q ? ST_T1 : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ph_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            ph_q    <= (state_q == ST_IDLE) ? 1'b0 : ~ph_q;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mc_q    <= MC_FETCH;
            addr_q  <= '0;
            wdata_q <= '0;
            chain_q <= 1'b0;
            oper_q  <= 1'b0;
            pc_q    <= RESET_PC;
        end else begin
            if ((state_q == ST_IDLE) && req_valid) begin
                chain_q <= 1'b0;
                oper_q  <= 1'b0;
                unique case (req_e'(req_kind))
                    RQ_FETCH: begin
                        mc_q   <= MC_FETCH;
                        addr_q <= pc_q;
                    end
                    RQ_LDI: begin
                        mc_q    <= MC_FETCH;
                        addr_q  <= pc_q;
                        chain_q <= 1'b1;
                    end
                    RQ_READ: begin
                        mc_q   <= MC_READ;
                        addr_q <= req_addr;
                    end
                    RQ_WRITE: begin
                        mc_q    <= MC_WRITE;
                        addr_q  <= req_addr;
                        wdata_q <= req_wdata;
                    end
                    default: mc_q <= MC_FETCH;
                endcase
            end
            if (cycle_end && chain_q) begin
                mc_q    <= MC_READ;
                addr_q  <= pc_q + 1'b1;
                chain_q <= 1'b0;
                oper_q  <= 1'b1;
            end
            if (cycle_end && ((mc_q == MC_FETCH) || oper_q)) begin
                pc_q <= pc_q + 1'b1;
            end
        end
    end

    AST_TSTATE_TWO_CLK: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q != $past(state_q)) && ($past(state_q) != ST_IDLE)) |-> $past(ph_q)); // R2

    AST_PC_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_q != $past(pc_q)) |-> (pc_q == $past(pc_q) + 1'b1)); // R7

    AST_CHAIN_NO_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (cycle_end && chain_q) |=> (state_q == ST_T1)); // R9

endmodule

// File: rtl/bus_pin_mux.sv
module bus_pin_mux
    import bus_seq_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  tstate_e          tstate,
    input  mc_e              mc,
    input  logic [AW-1:0]    cur_addr,
    input  logic [DW-1:0]    cur_wdata,
    output logic [AW-DW-1:0] addr_hi,
    output logic [DW-1:0]    ad_out,
    output logic             ad_oe,
    output logic             ale,
    output logic             rd_n,
    output logic             wr_n,
    output logic             busy
);

    localparam int HW = AW - DW;

    always_comb begin
        addr_hi = cur_addr[AW-1:DW];
        ad_out  = '0;
        ad_oe   = 1'b0;
        ale     = 1'b0;
        rd_n    = 1'b1;
        wr_n    = 1'b1;
        busy    = 1'b1;
        unique case (tstate)
            ST_IDLE: begin
                addr_hi = '0;
                busy    = 1'b0;
            end
            ST_T1: begin
                ale    = 1'b1;
                ad_oe  = 1'b1;
                ad_out = cur_addr[DW-1:0];
            end
            ST_T2, ST_T3: begin
                if (mc == MC_WRITE) begin
                    ad_oe  = 1'b1;
                    ad_out = cur_wdata;
                    wr_n   = 1'b0;
                end else begin
                    rd_n = 1'b0;
                end
            end
            ST_T4: begin
                ad_oe = 1'b0;
            end
            default: begin
                addr_hi = {HW{1'b0}};
                busy    = 1'b0;
            end
        endcase
    end

    AST_STROBES_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n)); // R4

    AST_ALE_DRIVES_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> (ad_oe && rd_n && wr_n)); // R3

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (rd_n && wr_n && !ale && !ad_oe)); // R1

    AST_READ_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !ad_oe); // R4

endmodule

// File: rtl/bus_capture_regs.sv
module bus_capture_regs
    import bus_seq_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cap_en,
    input  logic          cycle_end,
    input  mc_e           mc,
    input  logic [DW-1:0] ad_in,
    output logic [DW-1:0] opcode,
    output logic [DW-1:0] rdata,
    output logic          done
);

    logic done_q;
    logic done_half_q;

    assign done = done_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            opcode <= '0;
            rdata  <= '0;
        end else if (cap_en) begin
            if (mc == MC_FETCH) opcode <= ad_in;
            else                rdata  <= ad_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q      <= 1'b0;
            done_half_q <= 1'b0;
        end else if (cycle_end) begin
            done_q      <= 1'b1;
            done_half_q <= 1'b0;
        end else if (done_q) begin
            if (done_half_q) done_q <= 1'b0;
            done_half_q <= ~done_half_q;
        end
    end

    AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_q) |=> done_q); // R10

    AST_DONE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && $past(done_q)) |=> !done_q); // R10

endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
    import bus_seq_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8,
    parameter logic [AW-1:0] RESET_PC = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [1:0]       req_kind,
    input  logic [AW-1:0]    req_addr,
    input  logic [DW-1:0]    req_wdata,
    input  logic [DW-1:0]    ad_in,
    output logic             busy,
    output logic [AW-DW-1:0] addr_hi,
    output logic [DW-1:0]    ad_out,
    output logic             ad_oe,
    output logic             ale,
    output logic             rd_n,
    output logic             wr_n,
    output logic [DW-1:0]    opcode,
    output logic [DW-1:0]    rdata,
    output logic             done
);

    tstate_e       tstate;
    mc_e           mc;
    logic [AW-1:0] cur_addr;
    logic [DW-1:0] cur_wdata;
    logic          cap_en;
    logic          cycle_end;

    bus_cycle_fsm #(.AW(AW), .DW(DW), .RESET_PC(RESET_PC)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_kind  (req_kind),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .tstate    (tstate),
        .mc        (mc),
        .cur_addr  (cur_addr),
        .cur_wdata (cur_wdata),
        .cap_en    (cap_en),
        .cycle_end (cycle_end)
    );

    bus_pin_mux #(.AW(AW), .DW(DW)) u_pins (
        .clk       (clk),
        .rst_n     (rst_n),
        .tstate    (tstate),
        .mc        (mc),
        .cur_addr  (cur_addr),
        .cur_wdata (cur_wdata),
        .addr_hi   (addr_hi),
        .ad_out    (ad_out),
        .ad_oe     (ad_oe),
        .ale       (ale),
        .rd_n      (rd_n),
        .wr_n      (wr_n),
        .busy      (busy)
    );

    bus_capture_regs #(.DW(DW)) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_en    (cap_en),
        .cycle_end (cycle_end),
        .mc        (mc),
        .ad_in     (ad_in),
        .opcode    (opcode),
        .rdata     (rdata),
        .done      (done)
    );

    AST_BUSY_IGNORES_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && $stable(tstate)) |-> $stable(cur_addr)); // R11

endmodule

// File: tb/bus_cycle_seq_tb.sv
module bus_cycle_seq_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = 2'd0;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic [7:0]  ad_in = 8'hFF;
    logic        busy, ad_oe, ale, rd_n, wr_n, done;
    logic [7:0]  addr_hi, ad_out, opcode, rdata;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bus_cycle_seq u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_addr(req_addr), .req_wdata(req_wdata), .ad_in(ad_in),
        .busy(busy), .addr_hi(addr_hi), .ad_out(ad_out), .ad_oe(ad_oe),
        .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .opcode(opcode),
        .rdata(rdata), .done(done)
    );

    // behavioural memory on the shared bus
    logic [7:0] mem [logic [15:0]];
    logic [7:0] lat_lo = '0;

    function automatic logic [7:0] mem_rd(input logic [15:0] a);
        return mem.exists(a) ? mem[a] : 8'h00;
    endfunction

    always @(posedge clk) if (ale) lat_lo <= ad_out;

    always @(negedge clk) begin
        if (!wr_n) mem[{addr_hi, lat_lo}] = ad_out;
        ad_in <= rd_n ? 8'hFF : mem_rd({addr_hi, lat_lo});
    end

    // scoreboard: 0 opcode, 1 rdata, 2 no data
    int         q_sel[$];
    logic [7:0] q_val[$];
    string      q_tag[$];

    task automatic expect_item(input int sel, input logic [7:0] v, input string tag);
        q_sel.push_back(sel);
        q_val.push_back(v);
        q_tag.push_back(tag);
    endtask

    task automatic check(input bit ok, input string rq, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    // monitor
    logic done_d = 1'b0;
    int   done_run = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (done && !done_d) begin
                if (q_sel.size() == 0) begin
                    check(1'b0, "R10 unexpected done", 32'd1, 32'd0);
                end else begin
                    int sel;
                    logic [7:0] v;
                    string tag;
                    sel = q_sel.pop_front();
                    v   = q_val.pop_front();
                    tag = q_tag.pop_front();
                    if (sel == 0)      check(opcode == v, tag, {24'd0, opcode}, {24'd0, v});
                    else if (sel == 1) check(rdata == v, tag, {24'd0, rdata}, {24'd0, v});
                end
            end
            if (done) done_run++;
            else if (done_d) begin
                check(done_run == 2, "R10 done length", done_run, 32'd2);
                done_run = 0;
            end
            done_d <= done;
        end
    end

    task automatic issue(input int kind, input logic [15:0] a, input logic [7:0] wd);
        req_kind  = 2'(kind);
        req_addr  = a;
        req_wdata = wd;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // kind: 0 fetch, 1 read, 2 write; called at the first sample of T1
    task automatic run_cycle(input int kind, input logic [15:0] a, input logic [7:0] wd,
                             input string rq, input bit poke);
        int ntot;
        ntot = (kind == 0) ? 4 : 3;
        for (int t = 1; t <= ntot; t++) begin
            bit ok;
            logic [31:0] act, exp;
            ok = 1'b1;
            act = '0;
            exp = '0;
            for (int h = 0; h < 2; h++) begin
                bit e_ale, e_oe, e_rd, e_wr;
                logic [7:0] e_ad;
                e_ale = (t == 1);
                e_oe  = (t == 1) || (kind == 2 && t <= 3);
                e_rd  = !((t == 2 || t == 3) && kind != 2);
                e_wr  = !((t == 2 || t == 3) && kind == 2);
                e_ad  = (t == 1) ? a[7:0] : wd;
                if (ale !== e_ale || ad_oe !== e_oe || rd_n !== e_rd || wr_n !== e_wr ||
                    addr_hi !== a[15:8] || busy !== 1'b1 || (e_oe && ad_out !== e_ad)) begin
                    ok = 1'b0;
                    act = {4'(t), 3'd0, busy, addr_hi, (e_oe ? ad_out : 8'h00),
                           ale, ad_oe, rd_n, wr_n};
                    exp = {4'(t), 3'd0, 1'b1, a[15:8], (e_oe ? e_ad : 8'h00),
                           e_ale, e_oe, e_rd, e_wr};
                end
                if (poke && t == 2 && h == 0) begin
                    req_kind  = 2'd2;
                    req_addr  = 16'h0000;
                    req_wdata = 8'hEE;
                    req_valid = 1'b1;
                end
                if (poke && t == 2 && h == 1) req_valid = 1'b0;
                @(negedge clk);
            end
            check(ok, rq, act, exp);
        end
    endtask

    task automatic check_idle(input string rq);
        check(busy === 1'b0 && ale === 1'b0 && ad_oe === 1'b0 && rd_n === 1'b1 &&
              wr_n === 1'b1 && addr_hi === 8'h00, rq,
              {26'd0, busy, ale, ad_oe, rd_n, wr_n, |addr_hi},
              {26'd0, 6'b000110});
    endtask

    logic [15:0] mpc = 16'h0000;

    initial begin
        mem[16'h0000] = 8'h3E; mem[16'h0001] = 8'h32;
        mem[16'h0002] = 8'h4F; mem[16'h0003] = 8'h99;
        mem[16'h0004] = 8'h06; mem[16'h0005] = 8'hFF;
        mem[16'h2005] = 8'hA7; mem[16'hFFFF] = 8'h5A;

        repeat (3) @(negedge clk);
        check_idle("R1 in reset");
        check(done === 1'b0, "R1 done in reset", {31'd0, done}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check_idle("R1 after reset");

        // R9 load-immediate: fetch then operand read, no gap
        expect_item(0, 8'h3E, "R9 opcode");
        expect_item(1, 8'h32, "R9 operand");
        issue(3, 16'h0, 8'h0);
        run_cycle(0, mpc, 8'h0, "R9 R6 fetch phase", 1'b0);
        run_cycle(1, mpc + 16'd1, 8'h0, "R9 R4 operand phase", 1'b0);
        mpc += 16'd2;
        check_idle("R9 idle after seven T-states");

        // R7 plain fetch
        expect_item(0, 8'h4F, "R7 opcode");
        issue(0, 16'h1234, 8'h0);
        run_cycle(0, mpc, 8'h0, "R7 R2 fetch timing", 1'b0);
        mpc += 16'd1;

        // R8 read with R11 request raised mid-cycle
        expect_item(1, 8'hA7, "R8 read data");
        issue(1, 16'h2005, 8'h0);
        run_cycle(1, 16'h2005, 8'h0, "R8 R11 read timing", 1'b1);

        // R5 write then read back
        expect_item(2, 8'h00, "R5 write");
        issue(2, 16'h8123, 8'h5C);
        run_cycle(2, 16'h8123, 8'h5C, "R5 write timing", 1'b0);
        expect_item(1, 8'h5C, "R5 read back");
        issue(1, 16'h8123, 8'h0);
        run_cycle(1, 16'h8123, 8'h0, "R5 read back timing", 1'b0);

        // R11: the ignored write would have changed address 0
        expect_item(1, 8'h3E, "R11 no write at 0000");
        issue(1, 16'h0000, 8'h0);
        run_cycle(1, 16'h0000, 8'h0, "R11 read 0000 timing", 1'b0);

        // R3 top of address space
        expect_item(1, 8'h5A, "R3 read FFFF");
        issue(1, 16'hFFFF, 8'h0);
        run_cycle(1, 16'hFFFF, 8'h0, "R3 high byte FF", 1'b0);

        // R8 reads and writes left the program counter alone
        expect_item(0, 8'h99, "R8 fetch after read/write");
        issue(0, 16'h0, 8'h0);
        run_cycle(0, mpc, 8'h0, "R8 fetch address", 1'b0);
        mpc += 16'd1;

        // second load-immediate, operand at boundary value
        expect_item(0, 8'h06, "R9 second opcode");
        expect_item(1, 8'hFF, "R9 second operand");
        issue(3, 16'h0, 8'h0);
        run_cycle(0, mpc, 8'h0, "R9 second fetch", 1'b0);
        run_cycle(1, mpc + 16'd1, 8'h0, "R9 second operand", 1'b0);
        mpc += 16'd2;

        // R9 program counter advanced by two
        expect_item(0, 8'h00, "R9 fetch at pc+2");
        issue(0, 16'h0, 8'h0);
        run_cycle(0, mpc, 8'h0, "R9 pc plus two", 1'b0);

        repeat (4) @(negedge clk);
        check_idle("R1 idle at end");
        check(q_sel.size() == 0, "R10 all cycles signalled done", q_sel.size(), 32'd0);

        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule